// File: doc/BRIEF.md
# Indexed TLB Entry Writer with Flush Filtering

This block carries out one indexed write into a translation buffer entry. A request names the slot, carries the new tag fields (page-size exponent, virtual page-pair number, address-space id) and the two page words of the even/odd page pair, or asks only for the slot to be emptied. The block reads the entry that is being replaced. It decides whether translations derived from that entry may still be cached downstream, and emits up to two range-flush requests (a base address and a byte length each) before it commits the write. The entry storage stays outside the block. The block drives a read index and takes the old entry back on its inputs. It stores the result through a one-cycle write strobe.

The sequencer has six states. IDLE accepts a request. READ latches the old entry. DECIDE latches the flush decision. FLUSH_EVEN and FLUSH_ODD each present one range flush and wait for the flush handshake. COMMIT pulses the write strobe. The transitions are as follows. IDLE goes to READ on an accepted request. READ always goes to DECIDE. DECIDE goes to FLUSH_EVEN if the even half needs a flush, otherwise to FLUSH_ODD if the odd half needs one, otherwise to COMMIT. FLUSH_EVEN, once its flush is taken, goes to FLUSH_ODD if the odd half needs a flush, otherwise to COMMIT. FLUSH_ODD goes to COMMIT once its flush is taken. COMMIT always returns to IDLE. The page-word layout has the valid flag in bit 0 of each page word. The global flag is bit 1 of the even page word.

Top module: `tlb_pair_writer`

## Requirements
- R1: `req_ready` is high and `busy` low in IDLE. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle `busy` stays high and `req_ready` low through the COMMIT cycle. `busy` is low again in the cycle after COMMIT. Requests raised while busy are ignored.
- R2: With `req_ne` set, the commit writes back the old page-size, page-pair number, address-space id and both old page words with the existence flag cleared. None of the request's new fields are stored.
- R3: With `req_ne` set and the old entry already absent (E=0), no flush is issued and the entry stays absent.
- R4: With `req_ne` clear, the commit writes E=1, the request's page-size, page-pair number, address-space id and both request page words.
- R5: For a normal write, no flush is issued when the old entry exists with the same page size, page-pair number and address-space id, and each old half is either invalid (bit 0 clear) or equal in all bits to the new half.
- R6: Otherwise a flush is issued only if the old entry exists (E=1) and it is global (bit 1 of old even word) or its address-space id equals `cur_asid`.
- R7: The even flush base is the old page-pair number shifted left by 13, with its low ps+1 bits cleared, sign-extended from bit VA_W-1 to ADDR_W bits.
- R8: A flush of the even half is issued only if old even bit 0 is set, with length 2^ps at the base. A flush of the odd half is issued only if old odd bit 0 is set, with length 2^ps at base + 2^ps. The even flush always comes first.
- R9: A flush request keeps `fl_valid`, `fl_base` and `fl_len` steady until `fl_ready` is seen. The commit comes only after every needed flush has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_asid | input | ASID_W | Address-space id currently in use |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be taken |
| req_idx | input | IDX_W | Target slot |
| req_ne | input | 1 | Empty the slot instead of writing |
| req_ps | input | PS_W | New page-size exponent |
| req_vppn | input | VA_W-13 | New page-pair number |
| req_asid | input | ASID_W | New address-space id |
| req_lo0 | input | PAGE_W | New even page word |
| req_lo1 | input | PAGE_W | New odd page word |
| busy | output | 1 | Write in progress |
| rd_idx | output | IDX_W | Slot to read from storage |
| old_e | input | 1 | Old entry existence flag |
| old_ps | input | PS_W | Old page-size exponent |
| old_vppn | input | VA_W-13 | Old page-pair number |
| old_asid | input | ASID_W | Old address-space id |
| old_lo0 | input | PAGE_W | Old even page word |
| old_lo1 | input | PAGE_W | Old odd page word |
| fl_valid | output | 1 | Range flush request |
| fl_ready | input | 1 | Range flush taken |
| fl_base | output | ADDR_W | Flush base address |
| fl_len | output | ADDR_W | Flush length in bytes |
| wr_en | output | 1 | Commit strobe |
| wr_idx | output | IDX_W | Slot to write |
| wr_e | output | 1 | Existence flag to store |
| wr_ps | output | PS_W | Page-size exponent to store |
| wr_vppn | output | VA_W-13 | Page-pair number to store |
| wr_asid | output | ASID_W | Address-space id to store |
| wr_lo0 | output | PAGE_W | Even page word to store |
| wr_lo1 | output | PAGE_W | Odd page word to store |

## Verification
The bench sweeps 512 scenarios. Each scenario is a combination of nine choices: empty-only request, old existence, old even and odd valid bits, global flag, id match, tag equal or changed (page-pair number, id or page size), and page words equal or one half changed. The sweep also cycles through five page sizes and page-pair numbers with and without the top bit set. Changing only the half whose old valid bit is clear separates a correct skip from a flush-always design. Changing the half whose valid bit is set separates it from a skip-always design. Id mismatch on a non-global entry separates the ownership filter from an unconditional flush. Stalled flush handshakes and requests raised while busy test ordering and request rejection.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    localparam int unsigned PAGE_SHIFT = 13;
    localparam int unsigned VLD_BIT    = 0;
    localparam int unsigned GLB_BIT    = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_DECIDE,
        ST_FL_EVEN,
        ST_FL_ODD,
        ST_COMMIT
    } wr_state_e;
endpackage

// File: rtl/tlbw_keep_chk.sv
module tlbw_keep_chk
    import tlbw_pkg::*;
#(
    parameter int PS_W   = 6,
    parameter int VPPN_W = 35,
    parameter int ASID_W = 10,
    parameter int PAGE_W = 64
) (
    input  logic              ne,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              old_e,
    input  logic [PS_W-1:0]   old_ps,
    input  logic [VPPN_W-1:0] old_vppn,
    input  logic [ASID_W-1:0] old_asid,
    input  logic [PAGE_W-1:0] old_lo0,
    input  logic [PAGE_W-1:0] old_lo1,
    input  logic [PS_W-1:0]   new_ps,
    input  logic [VPPN_W-1:0] new_vppn,
    input  logic [ASID_W-1:0] new_asid,
    input  logic [PAGE_W-1:0] new_lo0,
    input  logic [PAGE_W-1:0] new_lo1,
    output logic              keep,
    output logic              flush_even,
    output logic              flush_odd
);
    logic tag_same;
    logic even_ok;
    logic odd_ok;
    logic owned;
    logic drop_old;

    // The new tag always carries E=1, so an absent old entry never matches.
    assign tag_same = old_e && (old_ps == new_ps) && (old_vppn == new_vppn)
                      && (old_asid == new_asid);
    assign even_ok  = !old_lo0[VLD_BIT] || (old_lo0 == new_lo0);
    assign odd_ok   = !old_lo1[VLD_BIT] || (old_lo1 == new_lo1);
    assign keep     = !ne && tag_same && even_ok && odd_ok;

    assign owned    = old_lo0[GLB_BIT] || (old_asid == cur_asid);
    assign drop_old = !keep && old_e && owned;

    assign flush_even = drop_old && old_lo0[VLD_BIT];
    assign flush_odd  = drop_old && old_lo1[VLD_BIT];
endmodule

// File: rtl/tlbw_span.sv
module tlbw_span
    import tlbw_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int ADDR_W = 64,
    parameter int PS_W   = 6
) (
    input  logic [PS_W-1:0]            ps,
    input  logic [VA_W-PAGE_SHIFT-1:0] vppn,
    input  logic                       odd,
    output logic [ADDR_W-1:0]          base,
    output logic [ADDR_W-1:0]          len
);
    localparam int VPPN_W = VA_W - PAGE_SHIFT;
    localparam int SH_W   = PS_W + 1;

    logic [VA_W-1:0]   raw;
    logic [VA_W-1:0]   low_mask;
    logic [VA_W-1:0]   trimmed;
    logic [SH_W-1:0]   pair_sh;
    logic [ADDR_W-1:0] even_base;

    assign raw      = {vppn, {PAGE_SHIFT{1'b0}}};
    assign pair_sh  = {1'b0, ps} + SH_W'(1);
    assign low_mask = ({{(VA_W-1){1'b0}}, 1'b1} << pair_sh) - {{(VA_W-1){1'b0}}, 1'b1};
    assign trimmed  = raw & ~low_mask;

    generate
        if (ADDR_W > VA_W) begin : g_extend
            assign even_base = {{(ADDR_W-VA_W){trimmed[VA_W-1]}}, trimmed};
        end else begin : g_same
            assign even_base = ADDR_W'(trimmed);
        end
    endgenerate

    assign len  = {{(ADDR_W-1){1'b0}}, 1'b1} << ps;
    assign base = odd ? (even_base + len) : even_base;
endmodule

// File: rtl/tlb_pair_writer.sv
module tlb_pair_writer
    import tlbw_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int PS_W   = 6,
    parameter int VA_W   = 48,
    parameter int ADDR_W = 64,
    parameter int ASID_W = 10,
    parameter int PAGE_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ASID_W-1:0]          cur_asid,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [IDX_W-1:0]           req_idx,
    input  logic                       req_ne,
    input  logic [PS_W-1:0]            req_ps,
    input  logic [VA_W-PAGE_SHIFT-1:0] req_vppn,
    input  logic [ASID_W-1:0]          req_asid,
    input  logic [PAGE_W-1:0]          req_lo0,
    input  logic [PAGE_W-1:0]          req_lo1,
    output logic                       busy,
    output logic [IDX_W-1:0]           rd_idx,
    input  logic                       old_e,
    input  logic [PS_W-1:0]            old_ps,
    input  logic [VA_W-PAGE_SHIFT-1:0] old_vppn,
    input  logic [ASID_W-1:0]          old_asid,
    input  logic [PAGE_W-1:0]          old_lo0,
    input  logic [PAGE_W-1:0]          old_lo1,
    output logic                       fl_valid,
    input  logic                       fl_ready,
    output logic [ADDR_W-1:0]          fl_base,
    output logic [ADDR_W-1:0]          fl_len,
    output logic                       wr_en,
    output logic [IDX_W-1:0]           wr_idx,
    output logic                       wr_e,
    output logic [PS_W-1:0]            wr_ps,
    output logic [VA_W-PAGE_SHIFT-1:0] wr_vppn,
    output logic [ASID_W-1:0]          wr_asid,
    output logic [PAGE_W-1:0]          wr_lo0,
    output logic [PAGE_W-1:0]          wr_lo1
);
    localparam int VPPN_W = VA_W - PAGE_SHIFT;

    wr_state_e state_q, state_d;

    // captured request
    logic [IDX_W-1:0]  idx_q;
    logic              ne_q;
    logic [PS_W-1:0]   ps_q;
    logic [VPPN_W-1:0] vppn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PAGE_W-1:0] lo0_q, lo1_q;
    // captured old entry
    logic              oe_q;
    logic [PS_W-1:0]   ops_q;
    logic [VPPN_W-1:0] ovppn_q;
    logic [ASID_W-1:0] oasid_q;
    logic [PAGE_W-1:0] olo0_q, olo1_q;
    // flush plan
    logic              fe_q, fo_q;

    logic keep_w, need_even, need_odd;
    logic [ADDR_W-1:0] span_base, span_len;

    tlbw_keep_chk #(
        .PS_W(PS_W), .VPPN_W(VPPN_W), .ASID_W(ASID_W), .PAGE_W(PAGE_W)
    ) u_keep (
        .ne(ne_q), .cur_asid(cur_asid),
        .old_e(oe_q), .old_ps(ops_q), .old_vppn(ovppn_q), .old_asid(oasid_q),
        .old_lo0(olo0_q), .old_lo1(olo1_q),
        .new_ps(ps_q), .new_vppn(vppn_q), .new_asid(asid_q),
        .new_lo0(lo0_q), .new_lo1(lo1_q),
        .keep(keep_w), .flush_even(need_even), .flush_odd(need_odd)
    );

    tlbw_span #(
        .VA_W(VA_W), .ADDR_W(ADDR_W), .PS_W(PS_W)
    ) u_span (
        .ps(ops_q), .vppn(ovppn_q), .odd(state_q == ST_FL_ODD),
        .base(span_base), .len(span_len)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_READ;
            ST_READ:    state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (need_even)     state_d = ST_FL_EVEN;
                else if (need_odd) state_d = ST_FL_ODD;
                else               state_d = ST_COMMIT;
            end
            ST_FL_EVEN: if (fl_ready) state_d = fo_q ? ST_FL_ODD : ST_COMMIT;
            ST_FL_ODD:  if (fl_ready) state_d = ST_COMMIT;
            ST_COMMIT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0; ne_q <= 1'b0; ps_q <= '0; vppn_q <= '0; asid_q <= '0;
            lo0_q <= '0; lo1_q <= '0;
            oe_q <= 1'b0; ops_q <= '0; ovppn_q <= '0; oasid_q <= '0;
            olo0_q <= '0; olo1_q <= '0;
            fe_q <= 1'b0; fo_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                idx_q  <= req_idx;
                ne_q   <= req_ne;
                ps_q   <= req_ps;
                vppn_q <= req_vppn;
                asid_q <= req_asid;
                lo0_q  <= req_lo0;
                lo1_q  <= req_lo1;
            end
            if (state_q == ST_READ) begin
                oe_q    <= old_e;
                ops_q   <= old_ps;
                ovppn_q <= old_vppn;
                oasid_q <= old_asid;
                olo0_q  <= old_lo0;
                olo1_q  <= old_lo1;
            end
            if (state_q == ST_DECIDE) begin
                fe_q <= need_even;
                fo_q <= need_odd;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        fl_valid  = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_READ, ST_DECIDE: ;
            ST_FL_EVEN, ST_FL_ODD: fl_valid = 1'b1;
            ST_COMMIT:  wr_en = 1'b1;
            default:    ;
        endcase
        busy    = !req_ready;
        rd_idx  = idx_q;
        wr_idx  = idx_q;
        fl_base = span_base;
        fl_len  = span_len;
        if (ne_q) begin
            wr_e    = 1'b0;
            wr_ps   = ops_q;
            wr_vppn = ovppn_q;
            wr_asid = oasid_q;
            wr_lo0  = olo0_q;
            wr_lo1  = olo1_q;
        end else begin
            wr_e    = 1'b1;
            wr_ps   = ps_q;
            wr_vppn = vppn_q;
            wr_asid = asid_q;
            wr_lo0  = lo0_q;
            wr_lo1  = lo1_q;
        end
    end

    // R1: an accepted request makes the block busy on the next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    // R1: the commit cycle is followed by an idle cycle
    p_commit_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !busy);

    // R9: a stalled flush holds its payload
    p_flush_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_base) && $stable(fl_len)));

    // R7: flush base is aligned to the flush length
    p_flush_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> ((fl_base & (fl_len - ADDR_W'(1))) == '0));

    // R8: flush length is a single power of two
    p_flush_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> ($countones(fl_len) == 1));

    // R6: flushes come only from an entry that existed
    p_flush_exists_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> oe_q);
endmodule

// File: tb/tlb_pair_writer_bench.sv
module tlb_pair_writer_bench;
    localparam int IDX_W = 3, PS_W = 5, VA_W = 20, ADDR_W = 32, ASID_W = 4, PAGE_W = 8;
    localparam int VPPN_W = VA_W - 13;
    localparam int NSLOT = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [ASID_W-1:0] cur_asid = '0;
    logic req_valid = 1'b0, req_ne = 1'b0, fl_ready = 1'b0;
    logic [IDX_W-1:0] req_idx = '0;
    logic [PS_W-1:0] req_ps = '0;
    logic [VPPN_W-1:0] req_vppn = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic [PAGE_W-1:0] req_lo0 = '0, req_lo1 = '0;
    logic req_ready, busy, fl_valid, wr_en, wr_e;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic old_e;
    logic [PS_W-1:0] old_ps, wr_ps;
    logic [VPPN_W-1:0] old_vppn, wr_vppn;
    logic [ASID_W-1:0] old_asid, wr_asid;
    logic [PAGE_W-1:0] old_lo0, old_lo1, wr_lo0, wr_lo1;
    logic [ADDR_W-1:0] fl_base, fl_len;

    // storage model
    logic st_e [NSLOT];
    logic [PS_W-1:0] st_ps [NSLOT];
    logic [VPPN_W-1:0] st_vppn [NSLOT];
    logic [ASID_W-1:0] st_asid [NSLOT];
    logic [PAGE_W-1:0] st_lo0 [NSLOT], st_lo1 [NSLOT];
    logic pre_en = 1'b0, pre_e = 1'b0;
    logic [IDX_W-1:0] pre_idx = '0;
    logic [PS_W-1:0] pre_ps = '0;
    logic [VPPN_W-1:0] pre_vppn = '0;
    logic [ASID_W-1:0] pre_asid = '0;
    logic [PAGE_W-1:0] pre_lo0 = '0, pre_lo1 = '0;

    always @(posedge clk) begin
        if (pre_en) begin
            st_e[pre_idx] <= pre_e; st_ps[pre_idx] <= pre_ps; st_vppn[pre_idx] <= pre_vppn;
            st_asid[pre_idx] <= pre_asid; st_lo0[pre_idx] <= pre_lo0; st_lo1[pre_idx] <= pre_lo1;
        end else if (wr_en) begin
            st_e[wr_idx] <= wr_e; st_ps[wr_idx] <= wr_ps; st_vppn[wr_idx] <= wr_vppn;
            st_asid[wr_idx] <= wr_asid; st_lo0[wr_idx] <= wr_lo0; st_lo1[wr_idx] <= wr_lo1;
        end
    end
    assign old_e = st_e[rd_idx];
    assign old_ps = st_ps[rd_idx];
    assign old_vppn = st_vppn[rd_idx];
    assign old_asid = st_asid[rd_idx];
    assign old_lo0 = st_lo0[rd_idx];
    assign old_lo1 = st_lo1[rd_idx];

    tlb_pair_writer #(.IDX_W(IDX_W), .PS_W(PS_W), .VA_W(VA_W), .ADDR_W(ADDR_W),
                      .ASID_W(ASID_W), .PAGE_W(PAGE_W)) u_tlb_pair_writer (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
        .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx), .req_ne(req_ne),
        .req_ps(req_ps), .req_vppn(req_vppn), .req_asid(req_asid),
        .req_lo0(req_lo0), .req_lo1(req_lo1), .busy(busy), .rd_idx(rd_idx),
        .old_e(old_e), .old_ps(old_ps), .old_vppn(old_vppn), .old_asid(old_asid),
        .old_lo0(old_lo0), .old_lo1(old_lo1),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_base(fl_base), .fl_len(fl_len),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_e(wr_e), .wr_ps(wr_ps), .wr_vppn(wr_vppn),
        .wr_asid(wr_asid), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1)
    );

    int n_chk = 0, n_bad = 0, rdy_cnt = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] even_base(input int ps, input int vppn);
        longint raw, b;
        raw = longint'(vppn) * 8192;
        b = raw - (raw % (longint'(1) << (ps + 1)));
        if (b >= (longint'(1) << (VA_W - 1))) b = b + 64'hFFF0_0000;
        return ADDR_W'(b);
    endfunction

    task automatic run_one(input int c);
        bit ne, oe, v0, v1, g, am, ts, ls, which, intrude;
        logic [IDX_W-1:0] idx;
        logic [ASID_W-1:0] ca, oa, na;
        logic [PS_W-1:0] ops, nps;
        logic [VPPN_W-1:0] ov, nv;
        logic [PAGE_W-1:0] o0, o1, n0, n1;
        bit keep, drop, exp_ev, exp_od, done, prev_stall;
        int exp_n, got_n;
        logic [ADDR_W-1:0] eb, el, exp_b[2], exp_l[2], got_b[4], got_l[4], prev_b;

        ne = c[0]; oe = c[1]; v0 = c[2]; v1 = c[3]; g = c[4]; am = c[5];
        ts = c[6]; ls = c[7]; which = c[8]; intrude = (c % 16) == 5;
        idx = IDX_W'(c % NSLOT);
        ca = ASID_W'(c % 13);
        oa = am ? ca : (ca ^ 4'h5);
        ops = PS_W'(12 + c % 5);
        ov = VPPN_W'((c * 37) ^ 7'h55);
        o0 = {5'(c * 7), 1'b0, g, v0};
        o1 = {5'(c * 11 + 3), 2'b10, v1};
        nps = ops; nv = ov; na = oa;
        if (!ts) begin
            case (c % 3)
                0: nv = ov ^ 7'h01;
                1: na = oa ^ 4'h1;
                default: nps = (ops == 16) ? PS_W'(12) : ops + 1'b1;
            endcase
        end
        n0 = o0; n1 = o1;
        if (!ls) begin
            if (which) n1 = o1 ^ 8'h80;
            else       n0 = o0 ^ 8'h80;
        end

        // expected behaviour from the requirements
        keep = !ne && oe && ts && (!v0 || n0 == o0) && (!v1 || n1 == o1);
        drop = !keep && oe && (g || am);
        exp_ev = drop && v0;
        exp_od = drop && v1;
        eb = even_base(int'(ops), int'(ov));
        el = ADDR_W'(1) << ops;
        exp_n = 0;
        if (exp_ev) begin exp_b[exp_n] = eb; exp_l[exp_n] = el; exp_n++; end
        if (exp_od) begin exp_b[exp_n] = eb + el; exp_l[exp_n] = el; exp_n++; end

        // preload old entry
        @(negedge clk);
        pre_en = 1'b1; pre_idx = idx; pre_e = oe; pre_ps = ops; pre_vppn = ov;
        pre_asid = oa; pre_lo0 = o0; pre_lo1 = o1;
        cur_asid = ca;
        @(negedge clk);
        pre_en = 1'b0;
        req_valid = 1'b1; req_idx = idx; req_ne = ne; req_ps = nps; req_vppn = nv;
        req_asid = na; req_lo0 = n0; req_lo1 = n1;
        chk(req_ready && !busy, "R1", "idle ready", longint'(req_ready), 1);
        @(posedge clk);

        got_n = 0; done = 1'b0; prev_stall = 1'b0; prev_b = '0;
        for (int cy = 0; cy < 100 && !done; cy++) begin
            @(negedge clk);
            rdy_cnt++;
            fl_ready = (rdy_cnt % 3) != 0;
            if (cy == 1 && intrude) begin
                req_valid = 1'b1; req_idx = idx ^ 3'b001; req_ne = 1'b1;
            end else begin
                req_valid = 1'b0; req_ne = ne; req_idx = idx;
            end
            if (prev_stall)
                chk(fl_valid && fl_base == prev_b, "R9", "stalled flush held",
                    longint'(fl_base), longint'(prev_b));
            chk(busy && !req_ready, "R1", "busy during write", longint'(busy), 1);
            if (wr_en) begin
                done = 1'b1;
                chk(got_n == exp_n, "R9", "flushes before commit", got_n, exp_n);
            end
            if (fl_valid && fl_ready) begin
                if (got_n < 4) begin got_b[got_n] = fl_base; got_l[got_n] = fl_len; end
                got_n++;
            end
            prev_stall = fl_valid && !fl_ready;
            prev_b = fl_base;
        end
        chk(done, "R1", "commit reached", longint'(done), 1);

        @(negedge clk);
        chk(!busy && req_ready, "R1", "idle after commit", longint'(busy), 0);
        if (ne) begin
            chk(got_n == exp_n, oe ? "R6" : "R3", "flush count on empty-only", got_n, exp_n);
            chk(st_e[idx] == 1'b0, "R2", "entry cleared", longint'(st_e[idx]), 0);
            chk(st_ps[idx] == ops && st_vppn[idx] == ov && st_asid[idx] == oa,
                "R2", "old tag kept", longint'(st_vppn[idx]), longint'(ov));
            chk(st_lo0[idx] == o0 && st_lo1[idx] == o1, "R2", "old page words kept",
                longint'({st_lo1[idx], st_lo0[idx]}), longint'({o1, o0}));
        end else begin
            chk(got_n == exp_n, keep ? "R5" : "R6", "flush count", got_n, exp_n);
            chk(st_e[idx] == 1'b1 && st_ps[idx] == nps && st_vppn[idx] == nv
                && st_asid[idx] == na, "R4", "new tag stored",
                longint'({st_e[idx], st_ps[idx], st_vppn[idx], st_asid[idx]}),
                longint'({1'b1, nps, nv, na}));
            chk(st_lo0[idx] == n0 && st_lo1[idx] == n1, "R4", "new page words stored",
                longint'({st_lo1[idx], st_lo0[idx]}), longint'({n1, n0}));
        end
        if (got_n == exp_n) begin
            for (int k = 0; k < exp_n; k++) begin
                chk(got_b[k] == exp_b[k], "R7", "flush base", longint'(got_b[k]),
                    longint'(exp_b[k]));
                chk(got_l[k] == exp_l[k], "R8", "flush length", longint'(got_l[k]),
                    longint'(exp_l[k]));
            end
        end
        if (intrude) begin
            @(negedge clk);
            chk(!busy && !wr_en, "R1", "request while busy ignored", longint'(busy), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < NSLOT; i++) begin
            st_e[i] = 1'b0; st_ps[i] = '0; st_vppn[i] = '0;
            st_asid[i] = '0; st_lo0[i] = '0; st_lo1[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(!busy && req_ready && !fl_valid && !wr_en, "R1", "reset state",
            longint'({busy, req_ready, fl_valid, wr_en}), 4'b0100);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 512; c++) run_one(c);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule